// File: doc/BRIEF.md
# Descriptor Submission Portal with Work Queue

This block sits on the device side of a memory-mapped page and turns 64-byte job descriptors written into that page into entries of an in-order work queue. A downstream execution engine takes them through a valid/ready dequeue port. Each write beat carries a page offset, a byte count, a submission kind and 512 bits of payload. Only a complete, slot-aligned 64-byte beat counts as a descriptor. Anything smaller or misaligned is dropped without a trace, so a descriptor is never built from fragments.

Two submission kinds exist. A posted store expects no reply, so a submitter may stream several of them back to back. An enqueue command always receives a status one cycle later: accept, retry or error. With the retry reply, several independent submitters can share one queue without locks, because a full queue refuses the descriptor openly and never loses it silently.

A static mode input selects dedicated operation, where posted stores are the valid kind, or shared operation, where enqueue commands are the valid kind. A submission of the wrong kind for the mode is rejected. Occupancy and two sticky error flags are visible at all times.

Top module: `desc_portal`

## Requirements
- R1: A submission is a beat with `wr_valid` high, `wr_bytes` equal to 64 and `wr_addr[5:0]` equal to zero. Any of the 64 slot offsets in the 4096-byte page (`wr_addr[11:6]` of any value) is equally valid.
- R2: A beat with `wr_bytes` other than 64, or with a nonzero `wr_addr[5:0]`, is ignored. It produces no reply, stores nothing and sets no flag, whatever its kind.
- R3: In dedicated mode (`cfg_shared` = 0), a posted store (`wr_kind` = 0) is stored when the queue has room, and no reply is produced for it.
- R4: In shared mode (`cfg_shared` = 1), an enqueue command (`wr_kind` = 1) that finds room is stored. `rsp_valid` is high for exactly the following cycle, with `rsp_code` = 0 (accept).
- R5: In shared mode, an enqueue command that finds the queue full is not stored. The following cycle it gets `rsp_valid` with `rsp_code` = 1 (retry).
- R6: In dedicated mode, a posted store that finds the queue full is dropped and sets `err_flags[0]` (overflow). The flag stays set until reset.
- R7: An enqueue command in dedicated mode is not stored and gets `rsp_code` = 2 (error) the following cycle. A posted store in shared mode is dropped, produces no reply and sets the sticky `err_flags[1]` (mode mismatch).
- R8: Stored descriptors leave in arrival order. `deq_valid` is high whenever the queue is not empty. The head leaves on a cycle where `deq_valid` and `deq_ready` are both high, and `deq_data` holds steady while the head waits.
- R9: `fill_level` gives the entry count after each edge and never exceeds DEPTH (default 16). Fullness is judged on the count before the edge, so a dequeue in the same cycle does not make room for a submission.
- R10: After reset the queue is empty, `deq_valid` and `rsp_valid` are low and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shared | input | 1 | 0 dedicated mode, 1 shared mode (held static while traffic flows) |
| wr_valid | input | 1 | Write beat present |
| wr_addr | input | 12 | Byte offset of the beat within the portal page |
| wr_bytes | input | 7 | Number of bytes the beat carries |
| wr_kind | input | 1 | 0 posted store, 1 enqueue command |
| wr_data | input | 512 | Descriptor payload |
| rsp_valid | output | 1 | Status reply for an enqueue command |
| rsp_code | output | 2 | 0 accept, 1 retry, 2 error |
| deq_valid | output | 1 | Queue head available |
| deq_ready | input | 1 | Consumer takes the head |
| deq_data | output | 512 | Queue head descriptor |
| fill_level | output | 5 | Number of queued descriptors |
| err_flags | output | 2 | Sticky flags: bit 0 overflow, bit 1 mode mismatch |

## Verification
The bench aims at the queue boundary. It fills the queue to exactly DEPTH entries and then submits in the same cycle as a dequeue. A design that judged fullness after the pop would accept there instead of refusing, and one that wrapped its count would lose the oldest descriptor. Partial and misaligned beats of both kinds are sent mid-stream. A filter that looked only at the byte count or only at the offset would store fragments or send stray replies. Wrong-kind submissions in each mode are also covered, since a mixed-up mode decode shows up as a descriptor stored without a reply or a reply sent for a posted store. Long stalls of the consumer expose a head that moves or changes before it is taken.

// File: rtl/portal_pkg.sv
package portal_pkg;

    typedef enum logic [1:0] {
        RSP_ACCEPT = 2'd0,
        RSP_RETRY  = 2'd1,
        RSP_ERROR  = 2'd2
    } rsp_code_e;

    typedef enum logic {
        SUB_POSTED  = 1'b0,
        SUB_ENQUEUE = 1'b1
    } sub_kind_e;

    // Outcome of one write beat, decided combinationally
    typedef struct packed {
        logic      push;
        logic      rsp_fire;
        rsp_code_e code;
        logic      set_ovf;
        logic      set_mis;
    } verdict_t;

endpackage

// File: rtl/portal_filter.sv
module portal_filter
    import portal_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DESC_W = 512
) (
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [6:0]           wr_bytes,
    input  logic                 wr_kind,
    input  logic                 shared_mode,
    input  logic                 q_full,
    output verdict_t             verdict
);
    localparam int DESC_BYTES = DESC_W / 8;
    localparam int OFS_W      = $clog2(DESC_BYTES);

    logic whole;
    logic unused_slot;

    // The slot index selects nothing: every slot feeds the same queue
    assign unused_slot = ^wr_addr[ADDR_W-1:OFS_W];

    assign whole = wr_valid
                 && (wr_bytes == 7'(DESC_BYTES))
                 && (wr_addr[OFS_W-1:0] == '0);

    always_comb begin
        verdict = '{push: 1'b0, rsp_fire: 1'b0, code: RSP_ACCEPT,
                    set_ovf: 1'b0, set_mis: 1'b0};
        if (whole) begin
            if (sub_kind_e'(wr_kind) == SUB_ENQUEUE) begin
                verdict.rsp_fire = 1'b1;
                if (!shared_mode) begin
                    verdict.code = RSP_ERROR;
                end else if (q_full) begin
                    verdict.code = RSP_RETRY;
                end else begin
                    verdict.code = RSP_ACCEPT;
                    verdict.push = 1'b1;
                end
            end else begin
                if (shared_mode) begin
                    verdict.set_mis = 1'b1;
                end else if (q_full) begin
                    verdict.set_ovf = 1'b1;
                end else begin
                    verdict.push = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/portal_fifo.sv
module portal_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 512
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [WIDTH-1:0]              push_data,
    input  logic                          pop_ready,
    output logic                          out_valid,
    output logic [WIDTH-1:0]              out_data,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t       st_d, st_q;
    logic [WIDTH-1:0]  mem_d [DEPTH];
    logic [WIDTH-1:0]  mem_q [DEPTH];
    logic              pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = mem_q[st_q.rptr];
    assign count     = st_q.cnt;
    assign full      = (st_q.cnt == CW'(DEPTH));
    assign pop       = out_valid && pop_ready;

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[st_q.wptr] = push_data;
            st_d.wptr        = bump(st_q.wptr);
        end
        if (pop) begin
            st_d.rptr = bump(st_q.rptr);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/portal_status.sv
module portal_status
    import portal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  verdict_t  verdict,
    output logic      rsp_valid,
    output logic [1:0] rsp_code,
    output logic [1:0] err_flags
);
    typedef struct packed {
        logic      rsp_v;
        rsp_code_e code;
        logic      ovf;
        logic      mis;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = verdict.rsp_fire;
        if (verdict.rsp_fire) begin
            st_d.code = verdict.code;
        end
        st_d.ovf = st_q.ovf | verdict.set_ovf;
        st_d.mis = st_q.mis | verdict.set_mis;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rsp_v: 1'b0, code: RSP_ACCEPT, ovf: 1'b0, mis: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_code  = st_q.code;
    assign err_flags = {st_q.mis, st_q.ovf};

endmodule

// File: rtl/desc_portal.sv
module desc_portal
    import portal_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DESC_W = 512,
    parameter int ADDR_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_shared,
    input  logic                        wr_valid,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [6:0]                  wr_bytes,
    input  logic                        wr_kind,
    input  logic [DESC_W-1:0]           wr_data,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_code,
    output logic                        deq_valid,
    input  logic                        deq_ready,
    output logic [DESC_W-1:0]           deq_data,
    output logic [$clog2(DEPTH+1)-1:0]  fill_level,
    output logic [1:0]                  err_flags
);
    verdict_t verdict;
    logic     q_full;

    portal_filter #(
        .ADDR_W (ADDR_W),
        .DESC_W (DESC_W)
    ) filter_i (
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_bytes    (wr_bytes),
        .wr_kind     (wr_kind),
        .shared_mode (cfg_shared),
        .q_full      (q_full),
        .verdict     (verdict)
    );

    portal_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (DESC_W)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (verdict.push),
        .push_data (wr_data),
        .pop_ready (deq_ready),
        .out_valid (deq_valid),
        .out_data  (deq_data),
        .count     (fill_level),
        .full      (q_full)
    );

    portal_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict   (verdict),
        .rsp_valid (rsp_valid),
        .rsp_code  (rsp_code),
        .err_flags (err_flags)
    );

endmodule

// File: rtl/portal_chk.sv
module portal_chk #(
    parameter int DEPTH  = 16,
    parameter int DESC_W = 512
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_shared,
    input  logic                        wr_valid,
    input  logic [5:0]                  slot_ofs,
    input  logic [6:0]                  wr_bytes,
    input  logic                        wr_kind,
    input  logic                        rsp_valid,
    input  logic [1:0]                  rsp_code,
    input  logic                        deq_valid,
    input  logic                        deq_ready,
    input  logic [DESC_W-1:0]           deq_data,
    input  logic [$clog2(DEPTH+1)-1:0]  fill_level,
    input  logic [1:0]                  err_flags
);
    localparam int CW = $clog2(DEPTH + 1);

    logic whole, partial, at_full;
    assign whole   = wr_valid && (wr_bytes == 7'd64) && (slot_ofs == 6'd0);
    assign partial = wr_valid && !whole;
    assign at_full = (fill_level == CW'(DEPTH));

    // R9: occupancy bounded by depth
    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    // R2: fragments produce no reply and grow nothing
    p_partial_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        partial |=> (!rsp_valid && fill_level <= $past(fill_level)));

    // R3: posted stores never get a reply
    p_posted_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (whole && !wr_kind) |=> !rsp_valid);

    // R4: every whole enqueue command is answered next cycle
    p_enq_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (whole && wr_kind) |=> rsp_valid);

    // R5: full shared queue answers retry and does not grow
    p_full_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (whole && wr_kind && cfg_shared && at_full)
            |=> (rsp_code == 2'd1 && fill_level <= $past(fill_level)));

    // R7: enqueue command in dedicated mode is an error
    p_mode_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (whole && wr_kind && !cfg_shared) |=> (rsp_code == 2'd2));

    // R6: overflow flag is sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[0] |=> err_flags[0]);

    // R7: mismatch flag is sticky
    p_mis_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[1] |=> err_flags[1]);

    // R8: stalled head stays put
    p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_data)));

endmodule

bind desc_portal portal_chk #(
    .DEPTH  (DEPTH),
    .DESC_W (DESC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_shared (cfg_shared),
    .wr_valid   (wr_valid),
    .slot_ofs   (wr_addr[5:0]),
    .wr_bytes   (wr_bytes),
    .wr_kind    (wr_kind),
    .rsp_valid  (rsp_valid),
    .rsp_code   (rsp_code),
    .deq_valid  (deq_valid),
    .deq_ready  (deq_ready),
    .deq_data   (deq_data),
    .fill_level (fill_level),
    .err_flags  (err_flags)
);

// File: tb/desc_portal_tb_top.sv
`timescale 1ns/1ps
module desc_portal_tb_top;
    localparam int DEPTH = 16;
    localparam int DW    = 512;
    localparam int CW    = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_shared = 1'b0;
    logic            wr_valid = 1'b0;
    logic [11:0]     wr_addr = '0;
    logic [6:0]      wr_bytes = '0;
    logic            wr_kind = 1'b0;
    logic [DW-1:0]   wr_data = '0;
    logic            rsp_valid;
    logic [1:0]      rsp_code;
    logic            deq_valid;
    logic            deq_ready = 1'b0;
    logic [DW-1:0]   deq_data;
    logic [CW-1:0]   fill_level;
    logic [1:0]      err_flags;

    always #4 clk = ~clk;

    desc_portal #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
        .wr_kind(wr_kind), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .deq_valid(deq_valid), .deq_ready(deq_ready), .deq_data(deq_data),
        .fill_level(fill_level), .err_flags(err_flags)
    );

    int            checks = 0;
    int            fails  = 0;
    string         phase  = "R10";
    logic [DW-1:0] mq[$];
    bit            m_rv = 0;
    int            m_code = 0;
    logic [1:0]    m_err = '0;

    task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(deq_valid == (mq.size() > 0), "deq_valid", DW'(deq_valid), DW'(mq.size() > 0));
        if (mq.size() > 0) chk(deq_data == mq[0], "deq_data", deq_data, mq[0]);
        chk(int'(fill_level) == mq.size(), "fill_level", DW'(fill_level), DW'(mq.size()));
        chk(rsp_valid == m_rv, "rsp_valid", DW'(rsp_valid), DW'(m_rv));
        if (m_rv) chk(int'(rsp_code) == m_code, "rsp_code", DW'(rsp_code), DW'(m_code));
        chk(err_flags == m_err, "err_flags", DW'(err_flags), DW'(m_err));
    endtask

    function automatic logic [DW-1:0] rnd_desc();
        logic [DW-1:0] d;
        for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    // One clock: drive at negedge, update model at the edge, compare at next negedge
    task automatic cyc(bit v, logic [11:0] a, logic [6:0] b, bit k, bit rdy);
        logic [DW-1:0] d = rnd_desc();
        bit whole, full, pop, push, nrv;
        int ncode;
        logic [1:0] nerr;
        wr_valid = v; wr_addr = a; wr_bytes = b; wr_kind = k; wr_data = d; deq_ready = rdy;
        whole = v && (b == 7'd64) && (a[5:0] == 6'd0);
        full  = (mq.size() == DEPTH);
        pop   = rdy && (mq.size() > 0);
        push  = 0; nrv = 0; ncode = m_code; nerr = m_err;
        if (whole) begin
            if (k) begin
                nrv = 1;
                if (!cfg_shared)  ncode = 2;
                else if (full)    ncode = 1;
                else begin ncode = 0; push = 1; end
            end else begin
                if (cfg_shared)   nerr[1] = 1'b1;
                else if (full)    nerr[0] = 1'b1;
                else              push = 1;
            end
        end
        @(posedge clk);
        if (pop)  void'(mq.pop_front());
        if (push) mq.push_back(d);
        m_rv = nrv; m_code = ncode; m_err = nerr;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n, bit rdy);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, rdy);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        phase = "R10";
        compare();
        idle(1, 0);

        // R1 / R3: posted stores to assorted slots, dedicated mode
        phase = "R1";
        cyc(1, 12'h000, 64, 0, 0);
        cyc(1, 12'hFC0, 64, 0, 0);
        cyc(1, 12'h140, 64, 0, 0);
        phase = "R3";
        cyc(1, 12'h7C0, 64, 0, 0);

        // R2: fragments and misaligned beats
        phase = "R2";
        cyc(1, 12'h080, 8, 0, 0);
        cyc(1, 12'h00C, 64, 0, 0);
        cyc(1, 12'h0C0, 32, 1, 0);
        cyc(1, 12'h104, 64, 1, 0);
        cyc(1, 12'h200, 0, 0, 0);

        // R6: fill to depth, then overflow
        phase = "R6";
        while (mq.size() < DEPTH) cyc(1, 12'h040, 64, 0, 0);
        cyc(1, 12'h300, 64, 0, 0);
        idle(2, 0);

        // R8: drain with a stuttering consumer
        phase = "R8";
        for (int i = 0; i < 40; i++) cyc(i % 3 == 0, 12'h080, 64, 0, i % 2 == 0);
        idle(20, 1);

        // R7: wrong kind per mode
        phase = "R7";
        cyc(1, 12'h000, 64, 1, 0);
        cfg_shared = 1'b1;
        cyc(1, 12'h040, 64, 0, 0);
        idle(1, 0);

        // R4: shared accepts
        phase = "R4";
        cyc(1, 12'h000, 64, 1, 0);
        cyc(1, 12'h040, 64, 1, 0);
        cyc(1, 12'h080, 64, 1, 1);

        // R5: fill then retry
        phase = "R5";
        while (mq.size() < DEPTH) cyc(1, 12'h0C0, 64, 1, 0);
        cyc(1, 12'h100, 64, 1, 0);
        cyc(1, 12'h140, 64, 1, 0);

        // R9: pop in same cycle as submission at full does not make room
        phase = "R9";
        cyc(1, 12'h180, 64, 1, 1);
        cyc(1, 12'h1C0, 64, 1, 1);
        idle(20, 1);

        // Mixed traffic in both modes
        phase = "R1";
        for (int i = 0; i < 600; i++) begin
            int pick = $urandom_range(0, 9);
            logic [6:0] b = (pick < 7) ? 7'd64 : (pick == 7 ? 7'd32 : 7'd8);
            logic [11:0] a = {6'($urandom), (pick == 9) ? 6'd4 : 6'd0};
            if (i % 150 == 0) begin
                cfg_shared = ~cfg_shared;
                phase = cfg_shared ? "R5" : "R6";
            end
            cyc($urandom_range(0, 3) != 0, a, b, $urandom_range(0, 7) != 0 ? cfg_shared : ~cfg_shared,
                $urandom_range(0, 2) == 0);
        end
        idle(DEPTH + 2, 1);

        summary();
        $finish;
    end

endmodule